// File: doc/BRIEF.md
# UART Interrupt Status and Modem Loopback Unit

This unit is the interrupt corner of a UART register block. It keeps an eleven-bit raw interrupt status word and an eleven-bit mask word. It turns them into six registered interrupt lines: one line for each interrupt group, plus one line that merges all of the groups. Other parts of the UART raise raw bits through a per-bit set vector. Software reads the raw and masked words back, and it clears raw bits by writing ones to a clear address. A write to the transmit data address raises the transmit interrupt.

The unit also holds the modem-control bits of the control register and drives the modem-status flags. In normal operation the flags follow the external modem inputs. When the loopback bit is set, the flags are copied from the control register's modem outputs instead. At the same moment the four modem-status interrupt bits are rebuilt from those copied levels. This rebuild happens on every control write made with loopback enabled, including a write that does nothing but turn loopback on.

Top module: `uart_irq_loopback`

## Requirements
- R1: `irq_comb` is high exactly when any of `irq_rx`, `irq_tx`, `irq_rt`, `irq_ms` or `irq_err` is high.
- R2: Raw bits are encoded as RI=0, CTS=1, DCD=2, DSR=3, RX=4, TX=5, RT=6, FE=7, PE=8, BE=9, OE=10. The groups are modem status (bits 0..3), RX (bit 4), TX (bit 5), RT (bit 6) and error (bits 7..10). Each group line is registered. It is high in the cycle after a change exactly when (raw AND mask) has a bit set inside its group.
- R3: Address map: 0 data, 1 control, 2 mask, 3 raw, 4 masked, 5 clear. Reading address 3 returns the raw word. Reading address 4 returns raw AND mask. Reading address 2 returns the mask. Reading address 1 returns the control bits.
- R4: A write to address 5 clears every raw bit that is set in the written value. Reading address 5 returns zero.
- R5: A write to address 0 sets raw bit 5 (TX).
- R6: Control bits: 0 loopback enable, 1 DTR, 2 RTS, 3 Out1, 4 Out2. `modem_flags` bits are RI=0, CTS=1, DCD=2, DSR=3. A control write with loopback enabled sets RI from Out2, CTS from RTS, DCD from Out1 and DSR from DTR.
- R7: A control write with loopback enabled replaces raw bits 0..3 with the new flag levels. Stale modem bits are dropped, and this applies even when the write only turns loopback on.
- R8: Writes to the raw (3) and masked (4) addresses change neither the raw word nor the mask.
- R9: Reset clears the raw word, the mask, the control bits and all six interrupt lines.
- R10: Each set bit of `evt_set` sets the matching raw bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: While loopback is off, `modem_flags` follows `modem_in` one cycle later. A control write without loopback leaves raw bits 0..3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| evt_set | input | 11 | Per-bit raw interrupt set requests |
| modem_in | input | 4 | External modem status levels (RI, CTS, DCD, DSR) |
| modem_flags | output | 4 | Modem status flags (RI, CTS, DCD, DSR) |
| irq_comb | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rt | output | 1 | Receive timeout interrupt line |
| irq_ms | output | 1 | Modem status interrupt line |
| irq_err | output | 1 | Error interrupt line |

## Verification
The group lines are tested by raising one raw bit at a time from each group, with every bit enabled, so that a crossed line or a missing combined term produces a distinct pattern on the six outputs. The same receive bit is then raised with the mask cleared, which separates raw readback from masked readback. The loopback path is driven with two control words whose modem outputs do not overlap, which exposes swapped flag mappings and stale modem bits that were not cleared. A separate write that only turns loopback on checks the immediate rebuild. Clear, set-versus-clear collision and writes to read-only addresses are checked against hand-computed raw words.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_IRQ   = 11;
    localparam int NUM_LINES = 6;
    localparam int CTRL_W    = 5;
    localparam int MS_W      = 4;

    // raw interrupt bit positions
    localparam int IRQ_RI  = 0;
    localparam int IRQ_CTS = 1;
    localparam int IRQ_DCD = 2;
    localparam int IRQ_DSR = 3;
    localparam int IRQ_RX  = 4;
    localparam int IRQ_TX  = 5;
    localparam int IRQ_RT  = 6;

    // control bit positions
    localparam int C_LBE  = 0;
    localparam int C_DTR  = 1;
    localparam int C_RTS  = 2;
    localparam int C_OUT1 = 3;
    localparam int C_OUT2 = 4;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_RAW   = 3'd3,
        SEL_MSKD  = 3'd4,
        SEL_CLEAR = 3'd5
    } reg_sel_e;

    localparam logic [NUM_IRQ-1:0] GRP_MS  = 11'h00F;
    localparam logic [NUM_IRQ-1:0] GRP_RX  = 11'h010;
    localparam logic [NUM_IRQ-1:0] GRP_TX  = 11'h020;
    localparam logic [NUM_IRQ-1:0] GRP_RT  = 11'h040;
    localparam logic [NUM_IRQ-1:0] GRP_ERR = 11'h780;

    // line index: 0 combined, 1 rx, 2 tx, 3 rt, 4 ms, 5 err
    function automatic logic [NUM_IRQ-1:0] line_mask(input int idx);
        case (idx)
            0:       line_mask = GRP_MS | GRP_RX | GRP_TX | GRP_RT | GRP_ERR;
            1:       line_mask = GRP_RX;
            2:       line_mask = GRP_TX;
            3:       line_mask = GRP_RT;
            4:       line_mask = GRP_MS;
            default: line_mask = GRP_ERR;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_IRQ-1:0] raw;
        logic [NUM_IRQ-1:0] mask;
        logic [CTRL_W-1:0]  ctrl;
        logic [MS_W-1:0]    flags;
    } irq_state_t;

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_IRQ-1:0]  evt_set,
    input  logic [MS_W-1:0]     modem_in,
    output logic [NUM_IRQ-1:0]  raw_d,
    output logic [NUM_IRQ-1:0]  mask_d,
    output logic [NUM_IRQ-1:0]  raw_q,
    output logic [NUM_IRQ-1:0]  mask_q,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic [MS_W-1:0]     flags_q
);

    irq_state_t st_d, st_q;
    logic [MS_W-1:0] lb_levels;

    // modem flag levels a control write would loop back
    always_comb begin
        lb_levels          = '0;
        lb_levels[IRQ_RI]  = wdata[C_OUT2];
        lb_levels[IRQ_CTS] = wdata[C_RTS];
        lb_levels[IRQ_DCD] = wdata[C_OUT1];
        lb_levels[IRQ_DSR] = wdata[C_DTR];
    end

    always_comb begin
        st_d = st_q;
        if (!st_q.ctrl[C_LBE]) begin
            st_d.flags = modem_in;
        end
        if (wr_en) begin
            case (reg_sel_e'(addr))
                SEL_DATA:  st_d.raw[IRQ_TX] = 1'b1;
                SEL_CTRL: begin
                    st_d.ctrl = wdata[CTRL_W-1:0];
                    if (wdata[C_LBE]) begin
                        st_d.flags = lb_levels;
                        st_d.raw[MS_W-1:0] = lb_levels;
                    end
                end
                SEL_MASK:  st_d.mask = wdata[NUM_IRQ-1:0];
                SEL_CLEAR: st_d.raw = st_d.raw & ~wdata[NUM_IRQ-1:0];
                default: ;
            endcase
        end
        st_d.raw = st_d.raw | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_d   = st_d.raw;
    assign mask_d  = st_d.mask;
    assign raw_q   = st_q.raw;
    assign mask_q  = st_q.mask;
    assign ctrl_q  = st_q.ctrl;
    assign flags_q = st_q.flags;

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
    import uart_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IRQ-1:0]    raw_d,
    input  logic [NUM_IRQ-1:0]    mask_d,
    output logic [NUM_LINES-1:0]  lines_q
);

    logic [NUM_IRQ-1:0]   active;
    logic [NUM_LINES-1:0] lines_d;

    assign active = raw_d & mask_d;

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        always_comb begin
            lines_d[gi] = |(active & line_mask(gi));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else begin
            lines_q <= lines_d;
        end
    end

endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]         addr,
    input  logic [NUM_IRQ-1:0] raw_q,
    input  logic [NUM_IRQ-1:0] mask_q,
    input  logic [CTRL_W-1:0]  ctrl_q,
    output logic [DATA_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            SEL_CTRL: rdata = DATA_W'(ctrl_q);
            SEL_MASK: rdata = DATA_W'(mask_q);
            SEL_RAW:  rdata = DATA_W'(raw_q);
            SEL_MSKD: rdata = DATA_W'(raw_q & mask_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_loopback.sv
module uart_irq_loopback
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [10:0]         evt_set,
    input  logic [3:0]          modem_in,
    output logic [3:0]          modem_flags,
    output logic                irq_comb,
    output logic                irq_rx,
    output logic                irq_tx,
    output logic                irq_rt,
    output logic                irq_ms,
    output logic                irq_err
);

    logic [NUM_IRQ-1:0]   raw_d, mask_d, raw_q, mask_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [NUM_LINES-1:0] lines_q;

    uart_irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .evt_set  (evt_set),
        .modem_in (modem_in),
        .raw_d    (raw_d),
        .mask_d   (mask_d),
        .raw_q    (raw_q),
        .mask_q   (mask_q),
        .ctrl_q   (ctrl_q),
        .flags_q  (modem_flags)
    );

    uart_irq_lines u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_d   (raw_d),
        .mask_d  (mask_d),
        .lines_q (lines_q)
    );

    uart_irq_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .addr   (addr),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .ctrl_q (ctrl_q),
        .rdata  (rdata)
    );

    assign irq_comb = lines_q[0];
    assign irq_rx   = lines_q[1];
    assign irq_tx   = lines_q[2];
    assign irq_rt   = lines_q[3];
    assign irq_ms   = lines_q[4];
    assign irq_err  = lines_q[5];

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [10:0]       evt_set,
    input logic [10:0]       raw_q,
    input logic [10:0]       mask_q,
    input logic              irq_comb,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              irq_rt,
    input logic              irq_ms,
    input logic              irq_err
);

    a_r1_combined_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq_comb == (irq_rx | irq_tx | irq_rt | irq_ms | irq_err));

    a_r2_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx == (raw_q[4] & mask_q[4]));

    a_r2_ms_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ms == |(raw_q[3:0] & mask_q[3:0]));

    a_r2_err_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == |(raw_q[10:7] & mask_q[10:7]));

    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5 && evt_set == '0) |=> ((raw_q & wdata[10:0]) == '0) || !$stable(wdata));

    a_r5_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> raw_q[5]);

    a_r7_ms_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && wdata[0] && evt_set == '0) |=>
        (raw_q[3:0] == {$past(wdata[1]), $past(wdata[3]), $past(wdata[2]), $past(wdata[4])}));

    a_r8_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 3'd3 || addr == 3'd4)) |=>
        (raw_q == ($past(raw_q) | $past(evt_set))) && $stable(mask_q));

endmodule

bind uart_irq_loopback uart_irq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .evt_set  (evt_set),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq_comb (irq_comb),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx),
    .irq_rt   (irq_rt),
    .irq_ms   (irq_ms),
    .irq_err  (irq_err)
);

// File: tb/uart_irq_loopback_test.sv
module uart_irq_loopback_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [10:0]   evt_set = '0;
    logic [3:0]    modem_in = '0;
    logic [3:0]    modem_flags;
    logic irq_comb, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    uart_irq_loopback #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_set(evt_set), .modem_in(modem_in),
        .modem_flags(modem_flags), .irq_comb(irq_comb), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
    );

    function automatic logic [5:0] lines();
        return {irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_comb};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        wr_en = 0; evt_set = '0; modem_in = '0; addr = '0; wdata = '0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [10:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        do_reset();
        rd(3'd3, d); check("R9 raw after reset", d, 0);
        rd(3'd2, d); check("R9 mask after reset", d, 0);
        rd(3'd1, d); check("R9 ctrl after reset", d, 0);
        check("R9 lines after reset", lines(), 0);
    endtask

    task automatic t_groups();
        logic [10:0] bits [5] = '{11'h010, 11'h020, 11'h040, 11'h004, 11'h200};
        logic [5:0]  exp  [5] = '{6'b000011, 6'b000101, 6'b001001, 6'b010001, 6'b100001};
        do_reset();
        wr(3'd2, 16'h07FF);
        for (int i = 0; i < 5; i++) begin
            pulse(bits[i]);
            check("R2 R1 group line pattern", lines(), exp[i]);
            wr(3'd5, 16'h07FF);
            check("R2 line drops after clear", lines(), 0);
        end
    endtask

    task automatic t_masked();
        logic [DW-1:0] d;
        do_reset();
        pulse(11'h010);
        check("R2 masked-off rx line low", lines(), 0);
        rd(3'd3, d); check("R3 raw readback", d, 16'h0010);
        rd(3'd4, d); check("R3 masked readback zero", d, 0);
        wr(3'd2, 16'h0030);
        check("R2 rx line after mask set", lines(), 6'b000011);
        rd(3'd4, d); check("R3 masked readback", d, 16'h0010);
    endtask

    task automatic t_clear();
        logic [DW-1:0] d;
        do_reset();
        pulse(11'h7F0);
        wr(3'd5, 16'h00A0);
        rd(3'd3, d); check("R4 partial clear", d, 16'h0750);
        rd(3'd5, d); check("R4 clear reads zero", d, 0);
    endtask

    task automatic t_tx();
        logic [DW-1:0] d;
        do_reset();
        wr(3'd2, 16'h0020);
        wr(3'd0, 16'h0041);
        rd(3'd3, d); check("R5 tx raw bit", d, 16'h0020);
        check("R5 tx line", lines(), 6'b000101);
    endtask

    task automatic t_loop();
        logic [DW-1:0] d;
        do_reset();
        wr(3'd2, 16'h000F);
        wr(3'd1, 16'h0013);
        check("R6 flags dtr out2", modem_flags, 4'h9);
        rd(3'd3, d); check("R7 ms raw from dtr out2", d, 16'h0009);
        check("R2 ms line in loopback", lines(), 6'b010001);
        wr(3'd1, 16'h000D);
        check("R6 flags rts out1", modem_flags, 4'h6);
        rd(3'd3, d); check("R7 stale ms bits dropped", d, 16'h0006);
        do_reset();
        wr(3'd1, 16'h001E);
        rd(3'd3, d); check("R11 ctrl write without loopback", d, 0);
        wr(3'd1, 16'h001F);
        rd(3'd3, d); check("R7 rebuild on enabling loopback", d, 16'h000F);
        check("R6 all flags looped", modem_flags, 4'hF);
    endtask

    task automatic t_ignore();
        logic [DW-1:0] d;
        do_reset();
        wr(3'd2, 16'h07FF);
        pulse(11'h030);
        wr(3'd3, 16'h07FF);
        wr(3'd4, 16'h0000);
        rd(3'd3, d); check("R8 raw unchanged", d, 16'h0030);
        rd(3'd2, d); check("R8 mask unchanged", d, 16'h07FF);
    endtask

    task automatic t_collide();
        logic [DW-1:0] d;
        do_reset();
        @(negedge clk);
        wr_en = 1; addr = 3'd5; wdata = 16'h0010; evt_set = 11'h010;
        @(negedge clk);
        wr_en = 0; evt_set = '0;
        rd(3'd3, d); check("R10 set wins over clear", d, 16'h0010);
    endtask

    task automatic t_noloop();
        logic [DW-1:0] d;
        do_reset();
        @(negedge clk);
        modem_in = 4'hA;
        @(negedge clk);
        check("R11 flags follow inputs", modem_flags, 4'hA);
        rd(3'd3, d); check("R11 inputs leave raw alone", d, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_groups();
                t_masked();
                t_clear();
                t_tx();
                t_loop();
                t_ignore();
                t_collide();
                t_noloop();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule